// File: doc/BRIEF.md
# Integer Arithmetic and Logic Unit with Full Unsigned Relations

This block is the combinational execute-stage arithmetic unit of a single-cycle 32-bit integer core. It takes two operands and a 5-bit operation code and returns one 32-bit result. The result follows its inputs with no register in between.

The supported operations are addition and subtraction, bitwise AND, OR and XOR, logical and arithmetic shifts, and a set of relational tests. A relational test returns 0 or 1 in the least significant bit, so a branch unit can take bit 0 directly as its taken condition. Beyond the usual unsigned less-than, the code set also has unsigned greater-or-equal and unsigned less-or-equal. This means no branch relation needs its operands swapped or its result inverted.

Top module: `alu_rv32u`

## Requirements
- R1: Code 00000 returns a + b and code 00001 returns a - b, both wrapping modulo 2^32.
- R2: Code 00010 returns a AND b, code 00011 returns a OR b, and code 00100 returns a XOR b.
- R3: Code 01001 returns 1 when a < b as unsigned 32-bit values, else 0.
- R4: Code 01010 returns 1 when a >= b as unsigned 32-bit values, else 0.
- R5: Code 01110 returns 1 when a <= b as unsigned 32-bit values, else 0.
- R6: Code 00110 returns 1 when a < b as two's-complement values, and code 00111 returns 1 when a >= b as two's-complement values; otherwise each returns 0.
- R7: Code 01000 returns 1 when a equals b, and code 01011 returns 1 when they differ; otherwise each returns 0.
- R8: Code 00101 shifts a left and code 01111 shifts a right, both filling with zeros. Code 01100 shifts a right and fills with copies of a[31].
- R9: Every shift uses only b[4:0] as the shift amount; b[31:5] has no effect.
- R10: Every relational code (00110, 00111, 01000, 01001, 01010, 01011, 01110) drives bits 31..1 of the result to zero.
- R11: Codes 01101 and 10000 through 11111 return zero.
- R12: The result is a combinational function of a, b and sel, with no state: the same inputs always give the same result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 32 | First operand |
| b | input | 32 | Second operand; low 5 bits are the shift amount |
| sel | input | 5 | Operation code |
| y | output | 32 | Result |

## Verification
The cases that are hard to reach are the ones where signed and unsigned order disagree, because there the borrow of the shared subtractor and the sign bits must be combined correctly. These are operand pairs that straddle 0x80000000 or use all-ones against small values. The stimulus aims at them directly: it pairs 0xFFFFFFFF with 1, pairs 0x80000000 with 0x7FFFFFFF, and uses equal operands, where greater-or-equal and less-or-equal must both give 1. A sweep over all 32 codes with the same operand pairs also reaches every unassigned code. Shift amounts with high bits of b set show that only the low five bits count.

// File: rtl/alu_rv32u_pkg.sv
package alu_rv32u_pkg;
   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'b00000,
      OP_SUB  = 5'b00001,
      OP_AND  = 5'b00010,
      OP_OR   = 5'b00011,
      OP_XOR  = 5'b00100,
      OP_SLL  = 5'b00101,
      OP_SLT  = 5'b00110,
      OP_SGE  = 5'b00111,
      OP_EQ   = 5'b01000,
      OP_LTU  = 5'b01001,
      OP_GEU  = 5'b01010,
      OP_NE   = 5'b01011,
      OP_SRA  = 5'b01100,
      OP_LEU  = 5'b01110,
      OP_SRL  = 5'b01111
   } alu_op_e;

   function automatic logic is_relational(input logic [OP_W-1:0] op);
      return op inside {OP_SLT, OP_SGE, OP_EQ, OP_LTU, OP_GEU, OP_NE, OP_LEU};
   endfunction
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              sub,
   output logic [DATA_W-1:0] sum,
   output logic              borrow
);
   logic [DATA_W:0] ext;

   always_comb begin
      ext    = {1'b0, a} + {1'b0, b ^ {DATA_W{sub}}} + {{DATA_W{1'b0}}, sub};
      sum    = ext[DATA_W-1:0];
      // On subtraction a missing carry-out means a < b unsigned
      borrow = sub & ~ext[DATA_W];
   end
endmodule

// File: rtl/alu_compare.sv
module alu_compare
   import alu_rv32u_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [OP_W-1:0]   op,
   input  logic              a_msb,
   input  logic              b_msb,
   input  logic [DATA_W-1:0] diff,
   input  logic              borrow,
   output logic              hit
);
   logic ltu, lts, same;

   always_comb begin
      same = (diff == '0);
      ltu  = borrow;
      lts  = (a_msb ^ b_msb) ? a_msb : diff[DATA_W-1];
      case (op)
         OP_SLT:  hit = lts;
         OP_SGE:  hit = ~lts;
         OP_EQ:   hit = same;
         OP_NE:   hit = ~same;
         OP_LTU:  hit = ltu;
         OP_GEU:  hit = ~ltu;
         OP_LEU:  hit = ltu | same;
         default: hit = 1'b0;
      endcase
   end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int DATA_W = 32,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] a,
   input  logic [SH_W-1:0]   amount,
   input  logic              left,
   input  logic              arith,
   output logic [DATA_W-1:0] res
);
   logic [DATA_W-1:0] a_rev, out_rev, stage_in;
   logic [DATA_W-1:0] stage [0:SH_W];
   logic              fill;

   for (genvar k = 0; k < DATA_W; k++) begin : g_rev
      assign a_rev[k]   = a[DATA_W-1-k];
      assign out_rev[k] = stage[SH_W][DATA_W-1-k];
   end

   assign fill     = arith & ~left & a[DATA_W-1];
   assign stage_in = left ? a_rev : a;
   assign stage[0] = stage_in;

   for (genvar i = 0; i < SH_W; i++) begin : g_stage
      localparam int STEP = 1 << i;
      assign stage[i+1] = amount[i] ? {{STEP{fill}}, stage[i][DATA_W-1:STEP]}
                                    : stage[i];
   end

   assign res = left ? out_rev : stage[SH_W];
endmodule

// File: rtl/alu_rv32u.sv
module alu_rv32u
   import alu_rv32u_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 5,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [SEL_W-1:0]  sel,
   output logic [DATA_W-1:0] y
);
   if (SEL_W != OP_W) begin : g_bad_sel
      $error("alu_rv32u: SEL_W must equal the package code width");
   end
   if ((1 << SH_W) != DATA_W || DATA_W < 8) begin : g_bad_width
      $error("alu_rv32u: DATA_W must be a power of two, at least 8");
   end

   logic [DATA_W-1:0] sum, shifted;
   logic              borrow, hit, do_sub, sh_left, sh_arith;

   assign do_sub   = (sel != OP_ADD);
   assign sh_left  = (sel == OP_SLL);
   assign sh_arith = (sel == OP_SRA);

   alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a(a), .b(b), .sub(do_sub), .sum(sum), .borrow(borrow)
   );

   alu_compare #(.DATA_W(DATA_W)) u_cmp (
      .op(sel), .a_msb(a[DATA_W-1]), .b_msb(b[DATA_W-1]),
      .diff(sum), .borrow(borrow), .hit(hit)
   );

   alu_shifter #(.DATA_W(DATA_W)) u_shift (
      .a(a), .amount(b[SH_W-1:0]), .left(sh_left), .arith(sh_arith),
      .res(shifted)
   );

   always_comb begin
      case (sel)
         OP_ADD, OP_SUB:          y = sum;
         OP_AND:                  y = a & b;
         OP_OR:                   y = a | b;
         OP_XOR:                  y = a ^ b;
         OP_SLL, OP_SRL, OP_SRA:  y = shifted;
         OP_SLT, OP_SGE, OP_EQ, OP_NE,
         OP_LTU, OP_GEU, OP_LEU:  y = {{(DATA_W-1){1'b0}}, hit};
         default:                 y = '0;
      endcase
   end
endmodule

// File: rtl/alu_rv32u_chk.sv
module alu_rv32u_chk
   import alu_rv32u_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int SEL_W  = 5
) (
   input logic [DATA_W-1:0] a,
   input logic [DATA_W-1:0] b,
   input logic [SEL_W-1:0]  sel,
   input logic [DATA_W-1:0] y
);
   always_comb begin
      if (!$isunknown({a, b, sel})) begin
         // R1 addition against a plain arithmetic model
         a_r1_add_wraps: assert (sel != OP_ADD || y == a + b);
         // R3 unsigned below
         a_r3_ltu: assert (sel != OP_LTU || y[0] == (a < b));
         // R4 unsigned at or above
         a_r4_geu: assert (sel != OP_GEU || y[0] == (a >= b));
         // R5 unsigned at or below
         a_r5_leu: assert (sel != OP_LEU || y[0] == (a <= b));
         // R10 relational results carry nothing above bit 0
         a_r10_zero_ext: assert (!is_relational(sel) || y[DATA_W-1:1] == '0);
         // R11 unassigned codes give zero
         a_r11_unused_zero: assert (!(sel == 5'b01101 || sel[SEL_W-1]) || y == '0);
      end
   end
endmodule

bind alu_rv32u alu_rv32u_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
   .a(a), .b(b), .sel(sel), .y(y)
);

// File: tb/alu_rv32u_tb.sv
module alu_rv32u_tb;
   typedef struct packed {
      logic [4:0]  sel;
      logic [31:0] a;
      logic [31:0] b;
      logic [31:0] y;
   } vec_t;

   localparam int NV = 22;
   localparam vec_t VEC [NV] = '{
      '{5'b00000, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},  // R1
      '{5'b00000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},  // R1 wrap
      '{5'b00001, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},  // R1
      '{5'b00010, 32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000},  // R2
      '{5'b00011, 32'hF0F0_F0F0, 32'h0F0F_0000, 32'hFFFF_F0F0},  // R2
      '{5'b00100, 32'hAAAA_AAAA, 32'hFFFF_0000, 32'h5555_AAAA},  // R2
      '{5'b00101, 32'h0000_0001, 32'h0000_001F, 32'h8000_0000},  // R8
      '{5'b01111, 32'h8000_0000, 32'h0000_0004, 32'h0800_0000},  // R8
      '{5'b01100, 32'h8000_0000, 32'h0000_0004, 32'hF800_0000},  // R8
      '{5'b00110, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},  // R6
      '{5'b00111, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},  // R6
      '{5'b01001, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},  // R3
      '{5'b01001, 32'h0000_0001, 32'hFFFF_FFFF, 32'h0000_0001},  // R3
      '{5'b01010, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0001},  // R4
      '{5'b01010, 32'h0000_0005, 32'h0000_0005, 32'h0000_0001},  // R4 equal
      '{5'b01110, 32'h0000_0005, 32'h0000_0005, 32'h0000_0001},  // R5 equal
      '{5'b01110, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_0000},  // R5
      '{5'b01000, 32'h0000_1234, 32'h0000_1234, 32'h0000_0001},  // R7
      '{5'b01011, 32'h0000_1234, 32'h0000_1234, 32'h0000_0000},  // R7
      '{5'b00101, 32'h0000_0003, 32'h0000_0021, 32'h0000_0006},  // R9
      '{5'b01101, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},  // R11
      '{5'b01100, 32'h7FFF_FFF0, 32'h0000_0004, 32'h07FF_FFFF}   // R8
   };

   logic        clk = 1'b0;
   logic [31:0] a = '0, b = '0;
   logic [4:0]  sel = '0;
   logic [31:0] y;
   int          n_run = 0, n_fail = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   alu_rv32u u_dut (.a(a), .b(b), .sel(sel), .y(y));

   function automatic string req_of(input logic [4:0] s);
      case (s)
         5'b00000, 5'b00001:                   return "R1";
         5'b00010, 5'b00011, 5'b00100:         return "R2";
         5'b01001:                             return "R3";
         5'b01010:                             return "R4";
         5'b01110:                             return "R5";
         5'b00110, 5'b00111:                   return "R6";
         5'b01000, 5'b01011:                   return "R7";
         5'b00101, 5'b01111, 5'b01100:         return "R8";
         default:                              return "R11";
      endcase
   endfunction

   function automatic logic [31:0] model(input logic [4:0] s,
                                         input logic [31:0] x, input logic [31:0] z);
      int unsigned sh;
      sh = int'(z % 32);
      case (s)
         5'b00000: return x + z;
         5'b00001: return x - z;
         5'b00010: return x & z;
         5'b00011: return x | z;
         5'b00100: return x ^ z;
         5'b00101: return x << sh;
         5'b01111: return x >> sh;
         5'b01100: return 32'($signed(x) >>> sh);
         5'b00110: return {31'd0, $signed(x) <  $signed(z)};
         5'b00111: return {31'd0, $signed(x) >= $signed(z)};
         5'b01000: return {31'd0, x == z};
         5'b01011: return {31'd0, x != z};
         5'b01001: return {31'd0, x <  z};
         5'b01010: return {31'd0, x >= z};
         5'b01110: return {31'd0, x <= z};
         default:  return 32'd0;
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] exp);
      n_run++;
      if (y !== exp) begin
         n_fail++;
         $display("FAIL %s sel=%b a=%h b=%h actual=%h expected=%h",
                  tag, sel, a, b, y, exp);
      end
   endtask

   task automatic apply(input logic [4:0] s, input logic [31:0] x,
                        input logic [31:0] z);
      @(posedge clk);
      sel = s; a = x; b = z;
      @(negedge clk);
   endtask

   initial begin
      logic [31:0] ops_a [6];
      logic [31:0] ops_b [6];
      logic [31:0] first;
      ops_a = '{32'hFFFF_FFFF, 32'h8000_0000, 32'h0000_0005, 32'h7FFF_FFFF,
                32'h1234_5678, 32'h0000_0000};
      ops_b = '{32'h0000_0001, 32'h7FFF_FFFF, 32'h0000_0005, 32'hFFFF_FFE3,
                32'h8765_4321, 32'hFFFF_FFFF};

      // Idle inputs: add of zeros gives zero (R1, R12)
      @(negedge clk);
      check("R1", 32'd0);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i].sel, VEC[i].a, VEC[i].b);
         check(req_of(VEC[i].sel), VEC[i].y);
      end

      // Sweep every code with corner operand pairs (all requirements, incl. R11)
      for (int s = 0; s < 32; s++) begin
         for (int k = 0; k < 6; k++) begin
            apply(5'(s), ops_a[k], ops_b[k]);
            check(req_of(5'(s)), model(5'(s), ops_a[k], ops_b[k]));
            if (5'(s) inside {5'b00110, 5'b00111, 5'b01000, 5'b01001,
                              5'b01010, 5'b01011, 5'b01110})
               check("R10", y & 32'h0000_0001);
         end
      end

      // R9: upper bits of b have no effect on any shift
      apply(5'b01111, 32'hF000_0000, 32'hFFFF_FFE4);
      check("R9", 32'h0F00_0000);
      apply(5'b01100, 32'hF000_0000, 32'h0000_0024);
      check("R9", 32'hFF00_0000);
      apply(5'b00101, 32'h0000_00FF, 32'h0000_0020);
      check("R9", 32'h0000_00FF);

      // R12: same inputs give same result after other activity
      apply(5'b01110, 32'h8000_0000, 32'h8000_0001);
      first = y;
      check("R12", 32'd1);
      apply(5'b00001, 32'h1111_1111, 32'h2222_2222);
      check("R1", 32'hEEEE_EEEF);
      apply(5'b01110, 32'h8000_0000, 32'h8000_0001);
      check("R12", first);

      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired: actual=timeout expected=completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule